// File: doc/BRIEF.md
# Broadcast Coherence Miss Requester

This block handles cache misses for one tile of a tiled multiprocessor that keeps its caches coherent by broadcasting. When the local cache reports a miss, the block takes it and sends a request message to the block's home tile. The home tile is chosen by interleaving on the low address bits just above the block offset. The home then spreads the request to the other tiles. Each of those tiles answers this requester directly, with either a plain acknowledgement or a message carrying the block. When the block is not on-chip, the home's memory reply fills the single data slot.

Because the network is unordered, replies can arrive in any order. The data reply can come first, last or anywhere in between. The block records which tiles have answered in a per-source bitmap. It finishes only when every tile other than itself has been heard from. At that point it hands the block to the cache and sends an unblock message to the home in the same cycle. Only one miss is in flight at a time. A second miss stalls until the first one has finished.

Top module: `bcast_miss_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1 and `tx_valid`, `fill_valid` and `err` are 0.
- R2: A miss is accepted in a cycle where `miss_valid` and `miss_ready` are both 1. In the next cycle the block presents a request message with type code 0, source `MY_ID`, the miss address, and destination `addr[BLK_OFF_W +: log2(N_TILES)]`, which is the home tile.
- R3: `fill_valid` stays 0 until a valid reply has been recorded from each of the `N_TILES-1` other tiles. It rises two cycles after the cycle in which the last missing reply is presented.
- R4: On completion, the block presents an unblock message with type code 4, destination the home tile and the miss address. `fill_valid` is 1 in exactly the cycle that this message is handshaken (`tx_valid && tx_ready`). `fill_addr` and `fill_data` carry the miss address and the payload of the data reply.
- R5: Reply types are acknowledgement (code 2) and data (code 3). Completion and fill data do not depend on where the single data reply falls in the arrival order.
- R6: A second reply from a tile that has already answered for the current miss is ignored. It neither counts toward completion nor replaces captured data.
- R7: While a miss is in flight, `miss_ready` is 0 and a new `miss_valid` produces no request message.
- R8: If a data reply arrives from a new tile after data has already been captured, `err` becomes 1 from the next cycle. The first data payload is kept.
- R9: If all replies arrive and none carries data, `err` is 1 in the fill cycle and `fill_data` is 0.
- R10: A reply is ignored if it does not match the current miss. That means a destination other than `MY_ID`, an address other than the miss address, a source equal to `MY_ID`, or a type other than ack or data.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, the outgoing message stays valid and unchanged.
- R12: `err` stays set until the next miss is accepted, and it is cleared in the cycle after that acceptance.

Stimulus and response ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache reports a miss |
| miss_addr | input | ADDR_W | Address of the missing block |
| miss_ready | output | 1 | Controller can take a miss |
| fill_valid | output | 1 | Fill to the cache, one cycle |
| fill_addr | output | ADDR_W | Address of the filled block |
| fill_data | output | DATA_W | Block payload |
| err | output | 1 | Reply set was inconsistent for the current miss |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Network takes the outgoing message |
| tx_type | output | 3 | Outgoing message type |
| tx_src | output | TILE_W | Outgoing source tile |
| tx_dst | output | TILE_W | Outgoing destination tile |
| tx_addr | output | ADDR_W | Outgoing block address |
| rx_valid | input | 1 | Incoming message valid |
| rx_type | input | 3 | Incoming message type |
| rx_src | input | TILE_W | Incoming source tile |
| rx_dst | input | TILE_W | Incoming destination tile |
| rx_addr | input | ADDR_W | Incoming block address |
| rx_data | input | DATA_W | Incoming payload |

## Verification
The reply collection is driven with the data reply placed first, last and in the middle of the acknowledgements. This shows that completion depends on the set of sources and not on their order. A sequence with a repeated acknowledgement tells a per-source bitmap apart from a plain counter, because a counter would finish one reply early. Sequences with two data replies, or with no data reply, exercise the error flag. Stray replies with the wrong destination, address or type, together with a stalled network port and a second miss raised mid-flight, show that only matching replies and accepted misses change state.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [2:0] {
    MSG_REQ   = 3'd0,
    MSG_FWD   = 3'd1,
    MSG_ACK   = 3'd2,
    MSG_DATA  = 3'd3,
    MSG_UNBLK = 3'd4
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_UNBLK = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/bmc_home_map.sv
module bmc_home_map #(
  parameter int ADDR_W    = 32,
  parameter int N_TILES   = 8,
  parameter int BLK_OFF_W = 6,
  localparam int TILE_W   = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TILE_W-1:0] home
);
  // Low-order interleave just above the block offset
  always_comb begin
    home = addr[BLK_OFF_W +: TILE_W];
  end
endmodule

// File: rtl/bmc_reply_tracker.sv
module bmc_reply_tracker #(
  parameter int N_TILES = 8,
  parameter int MY_ID   = 0,
  parameter int DATA_W  = 64,
  localparam int TILE_W = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rx_en,
  input  logic [TILE_W-1:0] rx_src,
  input  logic              rx_is_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              armed,
  output logic [N_TILES-1:0] seen,
  output logic              all_in,
  output logic              have_data,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  localparam logic [N_TILES-1:0] OTHERS = ~(N_TILES'(1) << MY_ID);

  logic [N_TILES-1:0] seen_q, seen_d;
  logic               have_q, have_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               err_q, err_d;
  logic               fresh;
  logic               src_ok;

  always_comb begin
    src_ok = (int'(rx_src) < N_TILES) && (int'(rx_src) != MY_ID);
    fresh  = rx_en && src_ok && !seen_q[rx_src];
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TILES; gi++) begin : g_bit
      always_comb begin
        if (clear)
          seen_d[gi] = 1'b0;
        else if (fresh && (int'(rx_src) == gi))
          seen_d[gi] = 1'b1;
        else
          seen_d[gi] = seen_q[gi];
      end
    end
  endgenerate

  always_comb begin
    all_in = (seen_q & OTHERS) == OTHERS;
    have_d = have_q;
    data_d = data_q;
    err_d  = err_q;
    if (clear) begin
      have_d = 1'b0;
      data_d = '0;
      err_d  = 1'b0;
    end else begin
      if (fresh && rx_is_data) begin
        if (have_q) begin
          err_d = 1'b1;
        end else begin
          have_d = 1'b1;
          data_d = rx_data;
        end
      end
      if (armed && all_in && !have_q)
        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      have_q <= 1'b0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      have_q <= have_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign seen      = seen_q;
  assign have_data = have_q;
  assign data      = data_q;
  assign err       = err_q;
endmodule

// File: rtl/bcast_miss_ctrl.sv
module bcast_miss_ctrl
  import bmc_pkg::*;
#(
  parameter int N_TILES   = 8,
  parameter int MY_ID     = 0,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BLK_OFF_W = 6,
  localparam int TILE_W   = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [2:0]        tx_type,
  output logic [TILE_W-1:0] tx_src,
  output logic [TILE_W-1:0] tx_dst,
  output logic [ADDR_W-1:0] tx_addr,
  input  logic              rx_valid,
  input  logic [2:0]        rx_type,
  input  logic [TILE_W-1:0] rx_src,
  input  logic [TILE_W-1:0] rx_dst,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data
);
  ctl_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [TILE_W-1:0]   home_q, home_d;
  logic [TILE_W-1:0]   home_calc;
  logic                accept;
  logic                rx_en;
  logic                rx_is_data;
  logic [N_TILES-1:0]  seen_q;
  logic                all_in;
  logic                have_data;
  logic [DATA_W-1:0]   cap_data;
  logic                in_wait;

  bmc_home_map #(
    .ADDR_W   (ADDR_W),
    .N_TILES  (N_TILES),
    .BLK_OFF_W(BLK_OFF_W)
  ) u_home (
    .addr(miss_addr),
    .home(home_calc)
  );

  always_comb begin
    in_wait    = (state_q == ST_WAIT);
    accept     = (state_q == ST_IDLE) && miss_valid;
    rx_is_data = (rx_type == MSG_DATA);
    rx_en      = in_wait && rx_valid
                 && (int'(rx_dst) == MY_ID)
                 && (rx_addr == addr_q)
                 && ((rx_type == MSG_ACK) || (rx_type == MSG_DATA));
  end

  bmc_reply_tracker #(
    .N_TILES(N_TILES),
    .MY_ID  (MY_ID),
    .DATA_W (DATA_W)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .rx_en     (rx_en),
    .rx_src    (rx_src),
    .rx_is_data(rx_is_data),
    .rx_data   (rx_data),
    .armed     (in_wait),
    .seen      (seen_q),
    .all_in    (all_in),
    .have_data (have_data),
    .data      (cap_data),
    .err       (err)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    home_d  = home_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = miss_addr;
          home_d  = home_calc;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (tx_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (all_in) state_d = ST_UNBLK;
      end
      ST_UNBLK: begin
        if (tx_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      home_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_d;
        home_q <= home_d;
      end
    end
  end

  // Outputs
  always_comb begin
    miss_ready = (state_q == ST_IDLE);
    tx_valid   = (state_q == ST_REQ) || (state_q == ST_UNBLK);
    tx_type    = (state_q == ST_UNBLK) ? MSG_UNBLK : MSG_REQ;
    tx_src     = TILE_W'(MY_ID);
    tx_dst     = home_q;
    tx_addr    = addr_q;
    fill_valid = (state_q == ST_UNBLK) && tx_ready;
    fill_addr  = addr_q;
    fill_data  = have_data ? cap_data : '0;
  end
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int N_TILES = 8,
  parameter int MY_ID   = 0,
  parameter int ADDR_W  = 32,
  localparam int TILE_W = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic               fill_valid,
  input logic               err,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [2:0]         tx_type,
  input logic [ADDR_W-1:0]  tx_addr,
  input logic [N_TILES-1:0] seen
);
  localparam logic [N_TILES-1:0] OTHERS = ~(N_TILES'(1) << MY_ID);

  p_req_follows_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (tx_valid && tx_type == 3'd0));

  p_fill_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ((seen & OTHERS) == OTHERS));

  p_fill_with_unblock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (tx_valid && tx_ready && tx_type == 3'd4));

  p_busy_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !miss_ready);

  p_msg_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_type) && $stable(tx_addr)));

  p_err_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !err);
endmodule

bind bcast_miss_ctrl bmc_checker #(
  .N_TILES(N_TILES),
  .MY_ID  (MY_ID),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .miss_valid(miss_valid),
  .miss_ready(miss_ready),
  .fill_valid(fill_valid),
  .err       (err),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_type   (tx_type),
  .tx_addr   (tx_addr),
  .seen      (seen_q)
);

// File: tb/tb_bcast_miss_ctrl.sv
module tb_bcast_miss_ctrl;
  localparam int N  = 8;
  localparam int ME = 2;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int OFF = 6;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic miss_valid;
  logic [AW-1:0] miss_addr;
  logic miss_ready, fill_valid, err, tx_valid, tx_ready;
  logic [AW-1:0] fill_addr, tx_addr, rx_addr;
  logic [DW-1:0] fill_data, rx_data;
  logic [2:0] tx_type, rx_type;
  logic [TW-1:0] tx_src, tx_dst, rx_src, rx_dst;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bcast_miss_ctrl #(.N_TILES(N), .MY_ID(ME), .ADDR_W(AW), .DATA_W(DW), .BLK_OFF_W(OFF)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ready(miss_ready), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data), .err(err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_type(tx_type), .tx_src(tx_src), .tx_dst(tx_dst), .tx_addr(tx_addr),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_src(rx_src), .rx_dst(rx_dst),
    .rx_addr(rx_addr), .rx_data(rx_data));
  logic rx_valid;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] home_of(input logic [AW-1:0] a);
    return a[OFF +: TW];
  endfunction

  task automatic reply(input int src, input logic [2:0] typ, input logic [DW-1:0] d,
                       input logic [AW-1:0] a, input int dst = ME);
    rx_valid = 1'b1; rx_type = typ; rx_src = TW'(src); rx_dst = TW'(dst);
    rx_addr = a; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic start_miss(input logic [AW-1:0] a);
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(tx_valid && tx_type == 3'd0, "R2", "request valid/type", {tx_valid, tx_type}, 4'b1000);
    chk(tx_dst == home_of(a) && tx_src == TW'(ME), "R2", "request dst/src", {tx_dst, tx_src}, {home_of(a), TW'(ME)});
    chk(tx_addr == a, "R2", "request addr", tx_addr, a);
    chk(err == 1'b0, "R12", "err cleared after accept", err, 0);
    @(negedge clk);
  endtask

  task automatic expect_done(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit e, input string req);
    chk(fill_valid == 1'b0, "R3", "fill not yet one cycle after last reply", fill_valid, 0);
    @(negedge clk);
    chk(fill_valid == 1'b1, req, "fill valid", fill_valid, 1);
    chk(tx_valid && tx_type == 3'd4 && tx_dst == home_of(a), "R4", "unblock to home",
        {tx_valid, tx_type, tx_dst}, {1'b1, 3'd4, home_of(a)});
    chk(fill_addr == a, "R4", "fill addr", fill_addr, a);
    chk(fill_data == d, req, "fill data", fill_data, d);
    chk(err == e, req, "err flag", err, e);
    @(negedge clk);
    chk(miss_ready == 1'b1 && fill_valid == 1'b0, "R4", "back to idle", {miss_ready, fill_valid}, 2'b10);
  endtask

  // Replies from all other tiles; data sent by tile at position dpos in order
  task automatic all_replies(input logic [AW-1:0] a, input int dpos, input logic [DW-1:0] d);
    int k = 0;
    for (int t = 0; t < N; t++) begin
      if (t != ME) begin
        if (k == dpos) reply(t, 3'd3, d, a);
        else reply(t, 3'd2, 64'hdead, a);
        k++;
        if (k < N - 1) chk(fill_valid == 1'b0, "R3", "no fill before all replies", fill_valid, 0);
      end
    end
  endtask

  task automatic t_reset;
    chk(miss_ready == 1 && tx_valid == 0 && fill_valid == 0 && err == 0, "R1", "reset state",
        {miss_ready, tx_valid, fill_valid, err}, 4'b1000);
  endtask

  task automatic t_order;
    logic [AW-1:0] a = 32'h0000_1140;
    start_miss(a); all_replies(a, 0, 64'h1111_0000_0000_0001); expect_done(a, 64'h1111_0000_0000_0001, 0, "R5");
    start_miss(a); all_replies(a, 6, 64'h2222_0000_0000_0002); expect_done(a, 64'h2222_0000_0000_0002, 0, "R5");
    start_miss(32'h0000_2080); all_replies(32'h0000_2080, 3, 64'h3333); expect_done(32'h0000_2080, 64'h3333, 0, "R5");
  endtask

  task automatic t_dup;
    logic [AW-1:0] a = 32'h0000_0fc0;
    start_miss(a);
    reply(0, 3'd3, 64'hAAAA, a);
    reply(1, 3'd2, 0, a);
    reply(1, 3'd2, 0, a);
    reply(0, 3'd3, 64'hBBBB, a);
    reply(3, 3'd2, 0, a); reply(4, 3'd2, 0, a); reply(5, 3'd2, 0, a); reply(6, 3'd2, 0, a);
    @(negedge clk); @(negedge clk);
    chk(fill_valid == 0 && tx_valid == 0, "R6", "duplicates did not complete", {fill_valid, tx_valid}, 0);
    chk(err == 0, "R6", "duplicate data not an error", err, 0);
    reply(7, 3'd2, 0, a);
    expect_done(a, 64'hAAAA, 0, "R6");
  endtask

  task automatic t_stray_and_stall;
    logic [AW-1:0] a = 32'h0000_0340;
    start_miss(a);
    miss_valid = 1'b1; miss_addr = 32'h0000_9999;
    @(negedge clk);
    chk(miss_ready == 0 && tx_valid == 0, "R7", "second miss stalled", {miss_ready, tx_valid}, 0);
    miss_valid = 1'b0;
    for (int t = 0; t < N; t++) if (t != ME) begin
      reply(t, 3'd2, 0, a, 5);
      reply(t, 3'd2, 0, a + 32'h40);
      reply(t, 3'd1, 0, a);
    end
    reply(ME, 3'd3, 64'h77, a);
    @(negedge clk); @(negedge clk);
    chk(fill_valid == 0 && tx_valid == 0, "R10", "stray replies ignored", {fill_valid, tx_valid}, 0);
    all_replies(a, 5, 64'h5A5A);
    expect_done(a, 64'h5A5A, 0, "R10");
  endtask

  task automatic t_errors;
    logic [AW-1:0] a = 32'h0000_0180;
    start_miss(a);
    reply(0, 3'd3, 64'hC0, a);
    reply(1, 3'd3, 64'hC1, a);
    chk(err == 1, "R8", "second data flags error", err, 1);
    for (int t = 3; t < N; t++) reply(t, 3'd2, 0, a);
    expect_done(a, 64'hC0, 1, "R8");
    chk(err == 1, "R12", "err holds while idle", err, 1);
    start_miss(a);
    all_replies(a, 99, 0);
    expect_done(a, 64'h0, 1, "R9");
  endtask

  task automatic t_backpressure;
    logic [AW-1:0] a = 32'h0000_01c0;
    tx_ready = 1'b0;
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    miss_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_type == 3'd0 && tx_addr == a, "R11", "request held",
          {tx_valid, tx_type}, 4'b1000);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    all_replies(a, 2, 64'hFEED);
    tx_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tx_valid && tx_type == 3'd4 && fill_valid == 0, "R4", "no fill without handshake",
        {tx_valid, tx_type, fill_valid}, {1'b1, 3'd4, 1'b0});
    tx_ready = 1'b1;
    #0;
    chk(fill_valid == 1 && fill_data == 64'hFEED, "R4", "fill on handshake", fill_data, 64'hFEED);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; miss_valid = 0; miss_addr = '0; tx_ready = 1'b1;
    rx_valid = 0; rx_type = '0; rx_src = '0; rx_dst = '0; rx_addr = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_dup();
    t_stray_and_stall();
    t_errors();
    t_backpressure();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule